// File: doc/BRIEF.md
# Channel Spread Quality Imager

This block reduces each detector channel's short waveform to a four-level quality code for data-quality monitoring. For every event, each channel delivers a block of eight consecutive 12-bit samples. The block forms their integer mean and the sum of squared deviations from that mean. It compares the sum against three programmable thresholds and keeps the resulting 2-bit code.

Codes are packed four to a byte, so a whole-detector snapshot costs two bits per channel. The bytes are framed into packets, each spanning a fixed number of events. A downstream transmitter takes the byte stream together with its packet-first and packet-last flags.

The input is a plain sample stream with a valid strobe, a marker on the first sample of each channel block, and a marker on the first block of an event. The deviation pass is pipelined behind a second sample store, so a new channel can start every eight valid samples without back-pressure.

Top module: `dq_image_builder`

## Requirements
- R1: While reset is asserted, and after reset until the first packed byte is due, `byte_valid_o` is low.
- R2: The mean of a block is the 15-bit sum of its eight samples shifted right by three (floor); for example, seven samples of v+1 and one of v give mean v.
- R3: The spread is the sum over the eight samples of (sample - mean)^2, held at full precision in 27 bits; eight samples alternating 0 and 4095 give 33538052.
- R4: The code is 0 if spread <= `thr_lo_i`, else 1 if spread <= `thr_mid_i`, else 2 if spread <= `thr_hi_i`, else 3 (thresholds ascending).
- R5: Four codes form one byte: channel index c of an event goes to bits [2*(c mod 4)+1 : 2*(c mod 4)], so the lowest channel sits in bits [1:0]; a byte is emitted after channel c with c mod 4 = 3.
- R6: A packet covers 128 complete events (256 bytes with 8 channels per event); `pkt_first_o` is high on the first byte of event 0 of a packet and `pkt_last_o` on the last byte of event 127; both are low on every other byte.
- R7: Channel blocks may follow each other back to back, and valid-low gaps between samples are allowed; no block is lost.
- R8: A sample carrying `chan_first_i` while a block is still open discards the open block and starts a new one with the same channel index.
- R9: A valid sample without `chan_first_i` while no block is open is ignored.
- R10: A block whose first sample carries `evt_first_i` gets channel index 0; otherwise each completed block takes the next index, wrapping after channel 7. An incomplete group of codes is discarded when index 0 starts a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | 12 | Sample value |
| chan_first_i | input | 1 | First sample of a channel block |
| evt_first_i | input | 1 | First block of an event (with chan_first_i) |
| thr_lo_i | input | 27 | Upper bound of code 0 |
| thr_mid_i | input | 27 | Upper bound of code 1 |
| thr_hi_i | input | 27 | Upper bound of code 2 |
| byte_valid_o | output | 1 | Packed byte strobe |
| byte_o | output | 8 | Four packed 2-bit codes |
| pkt_first_o | output | 1 | First byte of a packet |
| pkt_last_o | output | 1 | Last byte of a packet |

## Verification
The assertions assume that a block is finished or restarted before the next block completes. They also assume the three thresholds are ascending and stay fixed while a channel is being classified, about ten cycles after its last sample. The stimulus changes thresholds only in idle gaps of twenty cycles between events and always opens a block with `chan_first_i`. It also injects deliberate aborts, stray samples and a truncated event, because those are defined behaviours.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
  localparam int CODE_W = 2;
  localparam int CODES_PER_BYTE = 4;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dqs_capture.sv
module dqs_capture #(
  parameter int SAMPLE_W = 12,
  parameter int NSAMP    = 8,
  parameter int N_CHAN   = 8,
  localparam int SIDX_W  = $clog2(NSAMP),
  localparam int SUM_W   = SAMPLE_W + SIDX_W,
  localparam int CH_W    = $clog2(N_CHAN)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [SAMPLE_W-1:0]              sample_i,
  input  logic                             chan_first_i,
  input  logic                             evt_first_i,
  output logic                             ld_o,
  output logic [NSAMP-1:0][SAMPLE_W-1:0]   ld_samp_o,
  output logic [SUM_W-1:0]                 ld_sum_o,
  output logic [CH_W-1:0]                  ld_chan_o
);
  logic                           in_blk_q;
  logic [SIDX_W-1:0]              wr_q;
  logic [NSAMP-1:0][SAMPLE_W-1:0] samp_q;
  logic [SUM_W-1:0]               sum_q;
  logic [CH_W-1:0]                blk_chan_q, next_chan_q;
  logic                           last_s;

  assign last_s = valid_i && in_blk_q && !chan_first_i && (wr_q == SIDX_W'(NSAMP-1));

  always_comb begin
    ld_samp_o            = samp_q;
    ld_samp_o[NSAMP-1]   = sample_i;
  end
  assign ld_sum_o  = sum_q + SUM_W'(sample_i);
  assign ld_chan_o = blk_chan_q;
  assign ld_o      = last_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_blk_q    <= 1'b0;
      wr_q        <= '0;
      samp_q      <= '0;
      sum_q       <= '0;
      blk_chan_q  <= '0;
      next_chan_q <= '0;
    end else if (valid_i) begin
      if (chan_first_i) begin
        // restart: any open block is dropped, index is not consumed
        samp_q[0]  <= sample_i;
        sum_q      <= SUM_W'(sample_i);
        wr_q       <= SIDX_W'(1);
        in_blk_q   <= 1'b1;
        blk_chan_q <= evt_first_i ? '0 : next_chan_q;
      end else if (in_blk_q) begin
        samp_q[wr_q] <= sample_i;
        sum_q        <= sum_q + SUM_W'(sample_i);
        if (last_s) begin
          in_blk_q    <= 1'b0;
          wr_q        <= '0;
          next_chan_q <= (blk_chan_q == CH_W'(N_CHAN-1)) ? '0 : blk_chan_q + CH_W'(1);
        end else begin
          wr_q <= wr_q + SIDX_W'(1);
        end
      end
    end
  end

  AST_EVT_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && chan_first_i && evt_first_i |=> blk_chan_q == '0); // R10
  AST_STRAY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !chan_first_i && !in_blk_q |=> !in_blk_q && $stable(sum_q)); // R9
  AST_ABORT_KEEPS_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && chan_first_i && !evt_first_i |=> $stable(next_chan_q)); // R8
endmodule

// File: rtl/dqs_spread.sv
module dqs_spread #(
  parameter int SAMPLE_W = 12,
  parameter int NSAMP    = 8,
  parameter int N_CHAN   = 8,
  localparam int SIDX_W  = $clog2(NSAMP),
  localparam int SUM_W   = SAMPLE_W + SIDX_W,
  localparam int DEV_W   = 2*SAMPLE_W + SIDX_W,
  localparam int CH_W    = $clog2(N_CHAN)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ld_i,
  input  logic [NSAMP-1:0][SAMPLE_W-1:0] ld_samp_i,
  input  logic [SUM_W-1:0]               ld_sum_i,
  input  logic [CH_W-1:0]                ld_chan_i,
  output logic                           res_valid_o,
  output logic [DEV_W-1:0]               res_dev_o,
  output logic [CH_W-1:0]                res_chan_o
);
  localparam logic [DEV_W-1:0] SMAX    = DEV_W'((2**SAMPLE_W) - 1);
  localparam logic [DEV_W-1:0] DEV_MAX = SMAX * SMAX * DEV_W'(NSAMP);

  logic [NSAMP-1:0][SAMPLE_W-1:0] smp_q;
  logic [SAMPLE_W-1:0]            mean_q, cur_s, ad_s;
  logic [2*SAMPLE_W-1:0]          sq_s;
  logic [DEV_W-1:0]               acc_q, acc_nx;
  logic [SIDX_W-1:0]              cnt_q;
  logic                           busy_q;
  logic [CH_W-1:0]                chan_q;

  always_comb begin
    cur_s  = smp_q[cnt_q];
    ad_s   = (cur_s >= mean_q) ? cur_s - mean_q : mean_q - cur_s;
    sq_s   = ad_s * ad_s;
    acc_nx = acc_q + DEV_W'(sq_s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q       <= '0;
      mean_q      <= '0;
      acc_q       <= '0;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      chan_q      <= '0;
      res_valid_o <= 1'b0;
      res_dev_o   <= '0;
      res_chan_o  <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (busy_q) begin
        acc_q <= acc_nx;
        if (cnt_q == SIDX_W'(NSAMP-1)) begin
          res_valid_o <= 1'b1;
          res_dev_o   <= acc_nx;
          res_chan_o  <= chan_q;
          busy_q      <= 1'b0;
        end else begin
          cnt_q <= cnt_q + SIDX_W'(1);
        end
      end
      // a load may coincide with the final step of the previous block
      if (ld_i) begin
        smp_q  <= ld_samp_i;
        mean_q <= SAMPLE_W'(ld_sum_i >> SIDX_W);
        acc_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        chan_q <= ld_chan_i;
      end
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> (!busy_q || cnt_q == SIDX_W'(NSAMP-1))); // R7
  AST_DEV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_dev_o <= DEV_MAX); // R3
  AST_RESULT_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !busy_q || $past(ld_i)); // R7
endmodule

// File: rtl/dqs_classify.sv
module dqs_classify
  import dqs_pkg::*;
#(
  parameter int DEV_W  = 27,
  parameter int N_CHAN = 8,
  localparam int N_THR = 3,
  localparam int CH_W  = $clog2(N_CHAN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic [DEV_W-1:0] res_dev_i,
  input  logic [CH_W-1:0]  res_chan_i,
  input  logic [DEV_W-1:0] thr_lo_i,
  input  logic [DEV_W-1:0] thr_mid_i,
  input  logic [DEV_W-1:0] thr_hi_i,
  output logic             code_valid_o,
  output code_t            code_o,
  output logic [CH_W-1:0]  code_chan_o
);
  logic [N_THR-1:0][DEV_W-1:0] thr_s;
  logic [N_THR-1:0]            above_s;
  code_t                       code_s;

  assign thr_s = {thr_hi_i, thr_mid_i, thr_lo_i};

  // with ascending thresholds the count of exceeded bounds is the level
  for (genvar j = 0; j < N_THR; j++) begin : g_cmp
    assign above_s[j] = res_dev_i > thr_s[j];
  end

  always_comb begin
    code_s = '0;
    for (int j = 0; j < N_THR; j++) code_s = code_s + code_t'(above_s[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_valid_o <= 1'b0;
      code_o       <= '0;
      code_chan_o  <= '0;
    end else begin
      code_valid_o <= res_valid_i;
      if (res_valid_i) begin
        code_o      <= code_s;
        code_chan_o <= res_chan_i;
      end
    end
  end

  AST_RED_ABOVE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o && code_o == 2'd3 |-> $past(res_dev_i) > $past(thr_hi_i)); // R4
  AST_WHITE_AT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o && code_o == 2'd0 |-> $past(res_dev_i) <= $past(thr_lo_i)); // R4
endmodule

// File: rtl/dqs_packer.sv
module dqs_packer
  import dqs_pkg::*;
#(
  parameter int N_CHAN      = 8,
  parameter int EVT_PER_PKT = 128,
  localparam int CH_W       = $clog2(N_CHAN),
  localparam int EC_W       = (EVT_PER_PKT > 1) ? $clog2(EVT_PER_PKT) : 1,
  localparam int POS_W      = $clog2(CODES_PER_BYTE)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            code_valid_i,
  input  code_t           code_i,
  input  logic [CH_W-1:0] code_chan_i,
  output logic            byte_valid_o,
  output logic [7:0]      byte_o,
  output logic            pkt_first_o,
  output logic            pkt_last_o
);
  logic [7:0]       acc_q, nb_s;
  logic [POS_W-1:0] pos_s;
  logic [EC_W-1:0]  evt_q;
  logic             evt_end_s, grp_end_s;

  assign pos_s     = code_chan_i[POS_W-1:0];
  assign evt_end_s = code_chan_i == CH_W'(N_CHAN-1);
  assign grp_end_s = pos_s == POS_W'(CODES_PER_BYTE-1);

  always_comb begin
    nb_s = (pos_s == '0) ? 8'h00 : acc_q;
    nb_s[CODE_W*pos_s +: CODE_W] = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      evt_q        <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      pkt_first_o  <= 1'b0;
      pkt_last_o   <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      pkt_first_o  <= 1'b0;
      pkt_last_o   <= 1'b0;
      if (code_valid_i) begin
        acc_q <= nb_s;
        if (grp_end_s) begin
          byte_valid_o <= 1'b1;
          byte_o       <= nb_s;
          pkt_first_o  <= (evt_q == '0) && (code_chan_i == CH_W'(CODES_PER_BYTE-1));
          pkt_last_o   <= evt_end_s && (evt_q == EC_W'(EVT_PER_PKT-1));
        end
        if (evt_end_s)
          evt_q <= (evt_q == EC_W'(EVT_PER_PKT-1)) ? '0 : evt_q + EC_W'(1);
      end
    end
  end

  AST_BYTE_FOLLOWS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(code_valid_i)); // R5
  AST_LAST_FLAG_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_last_o |-> byte_valid_o); // R6
  AST_FIRST_FLAG_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_first_o |-> byte_valid_o && !pkt_last_o); // R6
endmodule

// File: rtl/dq_image_builder.sv
module dq_image_builder
  import dqs_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int NSAMP       = 8,
  parameter int N_CHAN      = 8,
  parameter int EVT_PER_PKT = 128,
  localparam int SIDX_W     = $clog2(NSAMP),
  localparam int SUM_W      = SAMPLE_W + SIDX_W,
  localparam int DEV_W      = 2*SAMPLE_W + SIDX_W,
  localparam int CH_W       = $clog2(N_CHAN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                chan_first_i,
  input  logic                evt_first_i,
  input  logic [DEV_W-1:0]    thr_lo_i,
  input  logic [DEV_W-1:0]    thr_mid_i,
  input  logic [DEV_W-1:0]    thr_hi_i,
  output logic                byte_valid_o,
  output logic [7:0]          byte_o,
  output logic                pkt_first_o,
  output logic                pkt_last_o
);
  logic                           ld_s;
  logic [NSAMP-1:0][SAMPLE_W-1:0] ld_samp_s;
  logic [SUM_W-1:0]               ld_sum_s;
  logic [CH_W-1:0]                ld_chan_s;
  logic                           res_valid_s;
  logic [DEV_W-1:0]               res_dev_s;
  logic [CH_W-1:0]                res_chan_s;
  logic                           code_valid_s;
  code_t                          code_s;
  logic [CH_W-1:0]                code_chan_s;

  dqs_capture #(.SAMPLE_W(SAMPLE_W), .NSAMP(NSAMP), .N_CHAN(N_CHAN)) u_capture (
    .clk_i, .rst_ni, .valid_i, .sample_i, .chan_first_i, .evt_first_i,
    .ld_o(ld_s), .ld_samp_o(ld_samp_s), .ld_sum_o(ld_sum_s), .ld_chan_o(ld_chan_s)
  );

  dqs_spread #(.SAMPLE_W(SAMPLE_W), .NSAMP(NSAMP), .N_CHAN(N_CHAN)) u_spread (
    .clk_i, .rst_ni, .ld_i(ld_s), .ld_samp_i(ld_samp_s), .ld_sum_i(ld_sum_s),
    .ld_chan_i(ld_chan_s), .res_valid_o(res_valid_s), .res_dev_o(res_dev_s),
    .res_chan_o(res_chan_s)
  );

  dqs_classify #(.DEV_W(DEV_W), .N_CHAN(N_CHAN)) u_classify (
    .clk_i, .rst_ni, .res_valid_i(res_valid_s), .res_dev_i(res_dev_s),
    .res_chan_i(res_chan_s), .thr_lo_i, .thr_mid_i, .thr_hi_i,
    .code_valid_o(code_valid_s), .code_o(code_s), .code_chan_o(code_chan_s)
  );

  dqs_packer #(.N_CHAN(N_CHAN), .EVT_PER_PKT(EVT_PER_PKT)) u_packer (
    .clk_i, .rst_ni, .code_valid_i(code_valid_s), .code_i(code_s),
    .code_chan_i(code_chan_s), .byte_valid_o, .byte_o, .pkt_first_o, .pkt_last_o
  );
endmodule

// File: tb/sim_dq_image_builder.sv
module sim_dq_image_builder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [11:0]   sample = '0;
  logic          chan_first = 1'b0;
  logic          evt_first = 1'b0;
  logic [DW-1:0] thr0 = '0, thr1 = '0, thr2 = '0;
  logic          byte_valid, pkt_first, pkt_last;
  logic [7:0]    byte_d;

  dq_image_builder u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sample_i(sample),
    .chan_first_i(chan_first), .evt_first_i(evt_first),
    .thr_lo_i(thr0), .thr_mid_i(thr1), .thr_hi_i(thr2),
    .byte_valid_o(byte_valid), .byte_o(byte_d),
    .pkt_first_o(pkt_first), .pkt_last_o(pkt_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, ev_num = 0, m_next = 0, m_evt = 0;
  bit finished = 1'b0;
  logic [7:0] m_byte = '0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R4";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint ref_dev(input logic [11:0] s[8]);
    int sum = 0; int mean; longint acc = 0;
    for (int i = 0; i < 8; i++) sum += int'(s[i]);
    mean = sum >> 3; // R2 floor mean
    for (int i = 0; i < 8; i++) begin
      longint d = longint'(s[i]) - longint'(mean);
      acc += d * d; // R3
    end
    return acc;
  endfunction

  function automatic logic [1:0] ref_code(input longint dev);
    if (dev <= longint'(thr0)) return 2'd0;
    if (dev <= longint'(thr1)) return 2'd1;
    if (dev <= longint'(thr2)) return 2'd2;
    return 2'd3; // R4
  endfunction

  task automatic model_block(input logic [11:0] s[8], input bit ef);
    int ch, pos;
    logic [1:0] c;
    c  = ref_code(ref_dev(s));
    ch = ef ? 0 : m_next;                 // R10
    m_next = (ch == 7) ? 0 : ch + 1;
    pos = ch % 4;
    if (pos == 0) m_byte = '0;
    m_byte[2*pos +: 2] = c;               // R5
    if (pos == 3) begin
      exp_q.push_back({(m_evt == 0 && ch == 3), (ch == 7 && m_evt == 127), m_byte}); // R6
      tag_q.push_back(cur_tag);
    end
    if (ch == 7) m_evt = (m_evt + 1) % 128;
  endtask

  task automatic drive(input bit v, input logic [11:0] s, input bit cf, input bit ef);
    @(negedge clk);
    valid = v; sample = s; chan_first = cf; evt_first = ef;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 12'h0, 1'b0, 1'b0);
  endtask

  task automatic send_block(input logic [11:0] s[8], input bit ef, input int gap);
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, s[i], i == 0, ef && i == 0);
      if (gap > 0 && i < 7) idle(gap);
    end
    model_block(s, ef);
  endtask

  task automatic send_partial(input bit ef, input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 12'($urandom_range(0, 4095)), i == 0, ef && i == 0);
  endtask

  task automatic send_stray(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 12'($urandom_range(0, 4095)), 1'b0, 1'b0);
  endtask

  task automatic fill(input int kind, input int ch, input int ev, output logic [11:0] s[8]);
    int base, k;
    base = (ev * 37 + ch * 113) % 4000;
    k = (ev + ch) % 8;
    for (int i = 0; i < 8; i++) begin
      case (kind)
        0: s[i] = 12'(base + ((i < k) ? 1 : 0));
        1: s[i] = ((i + ch) % 2 == 1) ? 12'hFFF : 12'h000;
        default: s[i] = 12'($urandom_range(0, 4095));
      endcase
    end
  endtask

  task automatic send_event(input int kind, input int gap);
    logic [11:0] s[8];
    for (int ch = 0; ch < 8; ch++) begin
      fill(kind, ch, ev_num, s);
      send_block(s, ch == 0, gap);
    end
    ev_num++;
    idle(20);
  endtask

  // monitor: compare each emitted byte with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && byte_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected byte", longint'({pkt_first, pkt_last, byte_d}), -1);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({pkt_first, pkt_last, byte_d} == e, t, "first/last/byte",
            longint'({pkt_first, pkt_last, byte_d}), longint'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(byte_valid == 1'b0, "R1", "valid in reset", byte_valid, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(byte_valid == 1'b0, "R1", "valid after reset", byte_valid, 0);
    end

    // R4 R5: level steps give spreads 0..7 against bounds 2/4/6
    thr0 = 2; thr1 = 4; thr2 = 6; cur_tag = "R4";
    for (int e = 0; e < 20; e++) send_event(0, 0);

    // R7: gaps between samples, blocks back to back
    cur_tag = "R7";
    for (int e = 0; e < 10; e++) send_event(0, (e % 3) + 1);

    // R2: floor mean, spread equals count of +1 samples
    thr0 = 0; thr1 = 1; thr2 = 6; cur_tag = "R2";
    for (int e = 0; e < 6; e++) send_event(0, 0);

    // R3: full-range spread 33538052 on each boundary side
    cur_tag = "R3";
    thr0 = 33538051; thr1 = 33538052; thr2 = 33538053;
    for (int e = 0; e < 3; e++) send_event(1, 0);
    thr0 = 33538050; thr1 = 33538051; thr2 = 33538051;
    for (int e = 0; e < 2; e++) send_event(1, 0);

    // R8: aborted blocks at event start and mid-event
    thr0 = 2; thr1 = 4; thr2 = 6; cur_tag = "R8";
    for (int e = 0; e < 2; e++) begin
      logic [11:0] s[8];
      for (int ch = 0; ch < 8; ch++) begin
        if (ch == 0 || ch == 5) send_partial(ch == 0, 3 + e);
        fill(0, ch, ev_num, s);
        send_block(s, ch == 0, 0);
      end
      ev_num++;
      idle(20);
    end

    // R9: stray samples with no open block
    cur_tag = "R9";
    for (int e = 0; e < 2; e++) begin
      logic [11:0] s[8];
      for (int ch = 0; ch < 8; ch++) begin
        fill(0, ch, ev_num, s);
        send_block(s, ch == 0, 0);
        send_stray(3);
      end
      ev_num++;
      idle(20);
    end

    // R10: truncated event of two channels, then a resynchronised event
    cur_tag = "R10";
    begin
      logic [11:0] s[8];
      for (int ch = 0; ch < 2; ch++) begin
        fill(0, ch + 3, ev_num, s);
        send_block(s, ch == 0, 0);
      end
      idle(20);
    end
    send_event(0, 0);

    // R6: random data and bounds across the packet boundary
    cur_tag = "R6";
    while (ev_num < 136) begin
      int unsigned a, b, c;
      a = $urandom_range(0, 2000000);
      b = a + $urandom_range(0, 4000000);
      c = b + $urandom_range(0, 8000000);
      thr0 = DW'(a); thr1 = DW'(b); thr2 = DW'(c);
      send_event(2, 0);
    end

    idle(40);
    chk(exp_q.size() == 0, "R6", "bytes still expected", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule